// File: doc/BRIEF.md
# Multi-Transfer Pixel Row Sequencer

This block drives the row control strobes of an image sensor whose pixels extend their full-well capacity by moving charge from the photodiode to an enlarged floating node several times per frame. For a programmed transfer count N, the sequencer issues N-1 transfer pulses while the row is still unselected. These pulses are spaced evenly through the integration time. It then selects the row and issues the last transfer, followed by the signal sample, the floating-node reset and the reset-level sample, in that order. This is the reverse of the usual reset-then-transfer order, and it is what lets the node keep charge from the earlier transfers.

Rows are visited in ascending order from row 0 to the last row. Each row ends with a one-cycle row-done strobe to the column readout. The transfer count, the gap length and the pulse width are captured when a frame begins and are held until the frame ends.

Top module: `mct_row_seq`

## Requirements
- R1: After an accepted frame start, rows 0 to NUM_ROWS-1 are visited in ascending order. Each row gives exactly one row_done pulse, and row_idx equals that row's number during the pulse. After the last row's row_done, all strobes stay low and no further row_done appears until the next frame start.
- R2: The transfer count input is clamped: 0 is taken as 1, and any value above 4 is taken as 4. The count, the gap length and the pulse width are captured in the cycle that frame_start is accepted. Changing these inputs during a frame has no effect on that frame.
- R3: With an effective count N, gap G and width W, xfer_gate pulses N-1 times while row_sel is low. Each of these pulses is preceded by G low cycles. row_sel rises N*G+(N-1)*W cycles after the row starts. The row starts in the cycle after frame_start is accepted, or in the cycle after the previous row_done.
- R4: While row_sel is high, the strobes occur in this order: xfer_gate, samp_sig, fd_reset, samp_rst. Each strobe is high for exactly W cycles. One idle cycle with row_sel high comes before the transfer and between consecutive strobes.
- R5: At most one of xfer_gate, samp_sig, fd_reset and samp_rst is high in any cycle. samp_sig, fd_reset and samp_rst are high only while row_sel is high.
- R6: row_sel falls in the cycle right after samp_rst ends, and row_done is high for exactly that one cycle. A full row therefore takes N*G+(N+3)*W+5 cycles, and a frame takes NUM_ROWS times that.
- R7: A frame_start that arrives while a frame is running is ignored. The frame keeps its row order and its length.
- R8: While rst_n is low and right after it is released, all strobes and row_done are low and row_idx is 0.
- R9: A gap length or a pulse width programmed as 0 is taken as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a frame when the sequencer is idle |
| xfer_count | input | 3 | Requested number of transfers per row (clamped to 1..4) |
| gap_cycles | input | CNT_W | Length in cycles of each integration gap |
| width_cycles | input | CNT_W | Length in cycles of each strobe pulse |
| row_idx | output | ROW_W | Index of the row being sequenced |
| row_sel | output | 1 | Row select |
| xfer_gate | output | 1 | Transfer gate pulse |
| fd_reset | output | 1 | Floating-node reset |
| samp_sig | output | 1 | Signal-level sample strobe |
| samp_rst | output | 1 | Reset-level sample strobe |
| row_done | output | 1 | One-cycle end-of-row handshake |

## Verification
The bench sweeps every transfer count from 0 to 7, so it covers both clamp edges and every legal value, together with gap and width values that include zero. In each frame it scrambles all three inputs and pulses frame_start a second time. A design that read its configuration live, or that restarted on the second pulse, would change the pre-selection pulse count or the frame length and fail those checks. Per row, the bench counts transfer pulses before selection, the timing of the select edge, the strobe order, each pulse width and the idle spacer cycles. This exposes the single-transfer case when it wrongly emits a pre-select pulse, resets placed before the transfer, overlapping strobes, and row_done pulses that are misplaced or doubled.

// File: rtl/mct_pkg.sv
package mct_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_GAP,
        PH_PRE,
        PH_SETTLE,
        PH_XFER,
        PH_SPC1,
        PH_SIG,
        PH_SPC2,
        PH_RST,
        PH_SPC3,
        PH_PRST,
        PH_DONE
    } phase_e;

    // Phase that follows a timed strobe once its width has elapsed.
    function automatic phase_e after_pulse(input phase_e ph);
        case (ph)
            PH_XFER: return PH_SPC1;
            PH_SIG:  return PH_SPC2;
            PH_RST:  return PH_SPC3;
            PH_PRST: return PH_DONE;
            default: return PH_IDLE;
        endcase
    endfunction

    // Phase that follows a one-cycle spacer.
    function automatic phase_e after_spacer(input phase_e ph);
        case (ph)
            PH_SETTLE: return PH_XFER;
            PH_SPC1:   return PH_SIG;
            PH_SPC2:   return PH_RST;
            PH_SPC3:   return PH_PRST;
            default:   return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/mct_cfg_latch.sv
module mct_cfg_latch #(
    parameter int CNT_W     = 16,
    parameter int XFER_IN_W = 3,
    parameter int MAX_XFER  = 4,
    parameter int NM1_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [XFER_IN_W-1:0] xfer_raw,
    input  logic [CNT_W-1:0]     gap_raw,
    input  logic [CNT_W-1:0]     wid_raw,
    output logic [NM1_W-1:0]     nm1,
    output logic [CNT_W-1:0]     gap_len,
    output logic [CNT_W-1:0]     wid_len
);

    localparam logic [XFER_IN_W-1:0] MAX_RAW = XFER_IN_W'(MAX_XFER);

    typedef struct packed {
        logic [NM1_W-1:0] nm1;
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] wid;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            if (xfer_raw == '0)
                cfg_d.nm1 = '0;
            else if (xfer_raw > MAX_RAW)
                cfg_d.nm1 = NM1_W'(MAX_XFER - 1);
            else
                cfg_d.nm1 = NM1_W'(xfer_raw - XFER_IN_W'(1));
            cfg_d.gap = (gap_raw == '0) ? CNT_W'(1) : gap_raw;
            cfg_d.wid = (wid_raw == '0) ? CNT_W'(1) : wid_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.nm1 <= '0;
            cfg_q.gap <= CNT_W'(1);
            cfg_q.wid <= CNT_W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign nm1     = cfg_q.nm1;
    assign gap_len = cfg_q.gap;
    assign wid_len = cfg_q.wid;

endmodule

// File: rtl/mct_row_fsm.sv
module mct_row_fsm
    import mct_pkg::*;
#(
    parameter int NUM_ROWS = 3000,
    parameter int CNT_W    = 16,
    parameter int NM1_W    = 2,
    parameter int ROW_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [NM1_W-1:0] nm1,
    input  logic [CNT_W-1:0] gap_len,
    input  logic [CNT_W-1:0] wid_len,
    output phase_e           phase,
    output logic [ROW_W-1:0] row,
    output logic             idle
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [NM1_W-1:0] npre;
        logic [ROW_W-1:0] row;
    } st_t;

    st_t st_q, st_d;
    logic gap_end, wid_end;

    always_comb begin
        st_d    = st_q;
        gap_end = (st_q.cnt == gap_len - CNT_W'(1));
        wid_end = (st_q.cnt == wid_len - CNT_W'(1));
        case (st_q.phase)
            PH_IDLE: begin
                if (frame_start) begin
                    st_d.phase = PH_GAP;
                    st_d.cnt   = '0;
                    st_d.npre  = '0;
                    st_d.row   = '0;
                end
            end
            PH_GAP: begin
                if (gap_end) begin
                    st_d.cnt   = '0;
                    st_d.phase = (st_q.npre == nm1) ? PH_SETTLE : PH_PRE;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_PRE: begin
                if (wid_end) begin
                    st_d.cnt   = '0;
                    st_d.npre  = st_q.npre + NM1_W'(1);
                    st_d.phase = PH_GAP;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_XFER, PH_SIG, PH_RST, PH_PRST: begin
                if (wid_end) begin
                    st_d.cnt   = '0;
                    st_d.phase = after_pulse(st_q.phase);
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_SETTLE, PH_SPC1, PH_SPC2, PH_SPC3: begin
                st_d.phase = after_spacer(st_q.phase);
            end
            PH_DONE: begin
                if (st_q.row == LAST_ROW) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.row   = st_q.row + ROW_W'(1);
                    st_d.phase = PH_GAP;
                    st_d.cnt   = '0;
                    st_d.npre  = '0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.npre  <= '0;
            st_q.row   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign row   = st_q.row;
    assign idle  = (st_q.phase == PH_IDLE);

endmodule

// File: rtl/mct_strobe_decode.sv
module mct_strobe_decode
    import mct_pkg::*;
(
    input  phase_e phase,
    output logic   row_sel,
    output logic   xfer_gate,
    output logic   fd_reset,
    output logic   samp_sig,
    output logic   samp_rst,
    output logic   row_done
);

    always_comb begin
        row_sel   = phase inside {PH_SETTLE, PH_XFER, PH_SPC1, PH_SIG,
                                  PH_SPC2, PH_RST, PH_SPC3, PH_PRST};
        xfer_gate = (phase == PH_PRE) || (phase == PH_XFER);
        samp_sig  = (phase == PH_SIG);
        fd_reset  = (phase == PH_RST);
        samp_rst  = (phase == PH_PRST);
        row_done  = (phase == PH_DONE);
    end

endmodule

// File: rtl/mct_row_seq.sv
module mct_row_seq
    import mct_pkg::*;
#(
    parameter int  NUM_ROWS  = 3000,
    parameter int  CNT_W     = 16,
    localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [2:0]       xfer_count,
    input  logic [CNT_W-1:0] gap_cycles,
    input  logic [CNT_W-1:0] width_cycles,
    output logic [ROW_W-1:0] row_idx,
    output logic             row_sel,
    output logic             xfer_gate,
    output logic             fd_reset,
    output logic             samp_sig,
    output logic             samp_rst,
    output logic             row_done
);

    localparam int MAX_XFER = 4;
    localparam int NM1_W    = $clog2(MAX_XFER);

    logic [NM1_W-1:0] nm1;
    logic [CNT_W-1:0] gap_len, wid_len;
    logic             idle;
    phase_e           phase;

    mct_cfg_latch #(
        .CNT_W(CNT_W), .XFER_IN_W(3), .MAX_XFER(MAX_XFER), .NM1_W(NM1_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(frame_start && idle),
        .xfer_raw(xfer_count), .gap_raw(gap_cycles), .wid_raw(width_cycles),
        .nm1(nm1), .gap_len(gap_len), .wid_len(wid_len)
    );

    mct_row_fsm #(
        .NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W), .NM1_W(NM1_W), .ROW_W(ROW_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .nm1(nm1), .gap_len(gap_len), .wid_len(wid_len),
        .phase(phase), .row(row_idx), .idle(idle)
    );

    mct_strobe_decode u_dec (
        .phase(phase), .row_sel(row_sel), .xfer_gate(xfer_gate),
        .fd_reset(fd_reset), .samp_sig(samp_sig), .samp_rst(samp_rst),
        .row_done(row_done)
    );

endmodule

// File: rtl/mct_row_seq_chk.sv
module mct_row_seq_chk #(
    parameter int NUM_ROWS = 3000,
    parameter int ROW_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic [ROW_W-1:0] row_idx,
    input logic             row_sel,
    input logic             xfer_gate,
    input logic             fd_reset,
    input logic             samp_sig,
    input logic             samp_rst,
    input logic             row_done
);

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({xfer_gate, fd_reset, samp_sig, samp_rst}) <= 1);

    assert_sel_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_sig || fd_reset || samp_rst) |-> row_sel);

    assert_sig_spacer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_sig) |-> !$past(xfer_gate));

    assert_rst_spacer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_rst) |-> !$past(fd_reset));

    assert_done_after_prst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> (!row_sel && $past(samp_rst) && $past(row_sel)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done);

    assert_row_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= ROW_W'(NUM_ROWS - 1));

    assert_row_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_idx) |-> ($past(row_done) || $past(frame_start)));

endmodule

bind mct_row_seq mct_row_seq_chk #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_idx(row_idx),
    .row_sel(row_sel), .xfer_gate(xfer_gate), .fd_reset(fd_reset),
    .samp_sig(samp_sig), .samp_rst(samp_rst), .row_done(row_done)
);

// File: tb/mct_row_seq_tb.sv
`timescale 1ns/1ps
module mct_row_seq_tb;

    localparam int ROWS  = 3;
    localparam int CW    = 8;
    localparam int RW    = $clog2(ROWS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [2:0]    xfer_count = '0;
    logic [CW-1:0] gap_cycles = '0;
    logic [CW-1:0] width_cycles = '0;
    logic [RW-1:0] row_idx;
    logic          row_sel, xfer_gate, fd_reset, samp_sig, samp_rst, row_done;

    always #2 clk = ~clk;

    mct_row_seq #(.NUM_ROWS(ROWS), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .xfer_count(xfer_count), .gap_cycles(gap_cycles),
        .width_cycles(width_cycles), .row_idx(row_idx), .row_sel(row_sel),
        .xfer_gate(xfer_gate), .fd_reset(fd_reset), .samp_sig(samp_sig),
        .samp_rst(samp_rst), .row_done(row_done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected configuration of the running frame
    int exp_n, exp_g, exp_w;
    string tag_n, tag_t;

    // Monitor state
    bit active = 0;
    bit done_flag = 0;
    int since_row, frame_cnt, frame_len, exp_row, pos, pre_cnt, rows_seen;
    int run_tx, run_sig, run_rst, run_prst;
    int width_err, excl_err, order_err, idle_err;
    bit p_sel, p_tx, p_sig, p_rst, p_prst;

    task automatic clear_errs();
        width_err = 0; excl_err = 0; order_err = 0; idle_err = 0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            active = 0; since_row = 0; frame_cnt = 0; pos = 0; pre_cnt = 0;
            run_tx = 0; run_sig = 0; run_rst = 0; run_prst = 0;
            p_sel = 0; p_tx = 0; p_sig = 0; p_rst = 0; p_prst = 0;
        end else begin
            if (frame_start && !active) begin
                active = 1; since_row = 0; frame_cnt = 0; exp_row = 0;
                pos = 0; pre_cnt = 0; rows_seen = 0;
            end
            if (active) frame_cnt++;
            if (!active && (row_sel || xfer_gate || fd_reset || samp_sig || samp_rst || row_done))
                idle_err++;

            if (row_sel && !p_sel)
                check(since_row == exp_n*exp_g + (exp_n-1)*exp_w, {tag_t, " select edge"},
                      since_row, exp_n*exp_g + (exp_n-1)*exp_w);
            since_row++;

            if ($countones({xfer_gate, fd_reset, samp_sig, samp_rst}) > 1) excl_err++;
            if ((samp_sig || fd_reset || samp_rst) && !row_sel) excl_err++;

            if (xfer_gate && !p_tx) begin
                if (!row_sel) pre_cnt++;
                else begin
                    if (pos != 0 || !p_sel) order_err++;
                    pos = 1;
                end
            end
            if (samp_sig && !p_sig) begin
                if (pos != 1 || p_tx) order_err++;
                pos = 2;
            end
            if (fd_reset && !p_rst) begin
                if (pos != 2 || p_sig) order_err++;
                pos = 3;
            end
            if (samp_rst && !p_prst) begin
                if (pos != 3 || p_rst) order_err++;
                pos = 4;
            end

            if (xfer_gate) run_tx++; else if (p_tx) begin if (run_tx != exp_w) width_err++; run_tx = 0; end
            if (samp_sig) run_sig++; else if (p_sig) begin if (run_sig != exp_w) width_err++; run_sig = 0; end
            if (fd_reset) run_rst++; else if (p_rst) begin if (run_rst != exp_w) width_err++; run_rst = 0; end
            if (samp_rst) run_prst++; else if (p_prst) begin if (run_prst != exp_w) width_err++; run_prst = 0; end

            if (row_done && active) begin
                rows_seen++;
                check(!row_sel && p_sel && p_prst, "R6 select falls with row_done", row_sel, 0);
                check(pos == 4, "R4 in-row strobe order", pos, 4);
                check(pre_cnt == exp_n - 1, {tag_n, " pre-select transfers"}, pre_cnt, exp_n - 1);
                check(int'(row_idx) == exp_row, "R1 row index at row_done", row_idx, exp_row);
                exp_row++; pos = 0; pre_cnt = 0; since_row = 0;
                if (int'(row_idx) == ROWS - 1) begin
                    active = 0;
                    frame_len = frame_cnt;
                    done_flag = 1;
                end
            end

            p_sel = row_sel; p_tx = xfer_gate; p_sig = samp_sig;
            p_rst = fd_reset; p_prst = samp_rst;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            check(0, "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int gvals[3] = '{0, 1, 3};
        int wvals[3] = '{0, 1, 2};
        clear_errs();
        exp_n = 1; exp_g = 1; exp_w = 1;
        tag_n = "R3"; tag_t = "R3";
        repeat (4) @(negedge clk);
        check(!(row_sel || xfer_gate || fd_reset || samp_sig || samp_rst || row_done) && row_idx == 0,
              "R8 outputs during reset", {row_sel, xfer_gate, fd_reset, samp_sig, samp_rst, row_done}, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!(row_sel || xfer_gate || fd_reset || samp_sig || samp_rst || row_done) && row_idx == 0,
              "R8 outputs after reset", {row_sel, xfer_gate, fd_reset, samp_sig, samp_rst, row_done}, 0);

        for (int n = 0; n < 8; n++) begin
            for (int gi = 0; gi < 3; gi++) begin
                for (int wi = 0; wi < 3; wi++) begin
                    int row_len;
                    exp_n = (n == 0) ? 1 : ((n > 4) ? 4 : n);
                    exp_g = (gvals[gi] == 0) ? 1 : gvals[gi];
                    exp_w = (wvals[wi] == 0) ? 1 : wvals[wi];
                    tag_n = (n == 0 || n > 4) ? "R2" : "R3";
                    tag_t = (gvals[gi] == 0 || wvals[wi] == 0) ? "R9" : "R3";
                    row_len = exp_n*exp_g + (exp_n+3)*exp_w + 5;
                    clear_errs();
                    done_flag = 0;
                    @(negedge clk);
                    #1;
                    xfer_count = 3'(n); gap_cycles = CW'(gvals[gi]); width_cycles = CW'(wvals[wi]);
                    frame_start = 1'b1;
                    @(negedge clk);
                    #1 frame_start = 1'b0;
                    // Mid-frame: scramble configuration and retrigger
                    repeat (10) @(negedge clk);
                    #1;
                    xfer_count = 3'((n + 3) % 8); gap_cycles = CW'(gvals[gi] + 2);
                    width_cycles = CW'(wvals[wi] + 1);
                    frame_start = 1'b1;
                    @(negedge clk);
                    #1 frame_start = 1'b0;
                    wait (done_flag);
                    repeat (4) @(negedge clk);
                    check(frame_len == ROWS*row_len, "R6 frame length (R2 latched config)", frame_len, ROWS*row_len);
                    check(rows_seen == ROWS, "R7 rows per frame with retrigger", rows_seen, ROWS);
                    check(width_err == 0, "R4 strobe widths", width_err, 0);
                    check(order_err == 0, "R4 strobe order and spacers", order_err, 0);
                    check(excl_err == 0, "R5 strobe exclusivity", excl_err, 0);
                    check(idle_err == 0, "R1 idle after last row", idle_err, 0);
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule